// File: doc/BRIEF.md
# Split Page-Size Translation Lookaside Buffer

This block caches linear-to-physical page translations for a paged 32-bit core. It keeps two independent arrays side by side. One holds 4 KB page translations and the other holds large (4 MB) page translations. Each array has 8 sets of 4 ways, so each holds 32 entries and the block holds 64. A lookup probes both arrays in the same cycle. One cycle later it reports either a hit with the physical address, a permission fault, or a miss.

Translations are installed by an external page walker through the fill port. Each set keeps its in-use entries in a strict most-recently-used to least-recently-used order, and keeps its unused ways in a free pool. A fill takes a free way when one exists. Otherwise it evicts the least-recently-used entry. A lookup hit moves the matching entry to the front of the order. A single-page invalidate drops the entry that matches in either array and returns it to the free pool. A flush empties both arrays in one cycle.

Each cycle carries one command, chosen in a fixed priority order: flush (CMD_FLUSH), then invalidate (CMD_INVAL), then fill (CMD_FILL), then lookup (CMD_LOOKUP). With no request the command is CMD_IDLE. A command that loses to a higher-priority one in the same cycle is dropped. The block has no multi-cycle states, and every command completes in the cycle it is accepted.

Top module: `split_tlb`

## Requirements
- R1: After reset every entry is free, so a lookup misses. rsp_valid is 0 until a lookup is accepted.
- R2: A lookup is accepted only when flush, inv_valid and fill_valid are all low. Priority is flush, then invalidate, then fill, then lookup. The response (rsp_valid=1) appears exactly one cycle after the lookup is accepted. A lookup that is not accepted gives no response.
- R3: The small-page array takes its set from address bits [14:12] and its tag from bits [31:15]. On a hit, rsp_paddr = {fill_frame[19:0], lk_addr[11:0]}.
- R4: The large-page array takes its set from address bits [24:22] and its tag from bits [31:25]. On a hit, rsp_paddr = {fill_frame[19:10], lk_addr[21:0]}, and fill_frame[9:0] is ignored.
- R5: If both arrays hit, the small-page translation is reported.
- R6: A hit gives a fault when the lookup is a write (lk_write=1) to an entry stored with fill_wr=0. It also gives a fault when the lookup is a user access (lk_user=1) to an entry stored with fill_usr=0. A fault reports rsp_fault=1, rsp_hit=0 and rsp_paddr=0. A miss reports hit=0, fault=0 and paddr=0.
- R7: A fill whose page is already cached updates that entry in place. Otherwise the fill takes a free way. In both cases the filled entry becomes most-recently-used.
- R8: A lookup hit makes the entry most-recently-used. A fill into a set with no free way evicts the least-recently-used entry.
- R9: An invalidate whose address falls in a cached page drops that entry from either array and returns it to the free pool. The next fill to that set uses the freed way and evicts nothing.
- R10: A flush frees every entry of both arrays within one cycle.
- R11: The two arrays are independent. Fills and evictions in one array never remove entries from the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup linear address |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup is a user-level access |
| fill_valid | input | 1 | Install a translation |
| fill_large | input | 1 | Fill targets the large-page array |
| fill_addr | input | 32 | Linear address of the page being filled |
| fill_frame | input | 20 | Physical frame number (upper 10 bits for large pages) |
| fill_wr | input | 1 | Page is writable |
| fill_usr | input | 1 | Page is user-accessible |
| inv_valid | input | 1 | Invalidate the page containing inv_addr |
| inv_addr | input | 32 | Address to invalidate |
| flush | input | 1 | Free all entries |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Translation found and access permitted |
| rsp_fault | output | 1 | Translation found but access forbidden |
| rsp_paddr | output | 32 | Physical address on a hit, else zero |

## Verification
The bench fills a small-page set, touches its oldest entry and then overfills the set. If promotion were missing or the victim choice were wrong, the touched entry would be evicted in place of the true least-recently-used one. It invalidates one way of a full set and refills it. A design that failed to return the way to the free pool would evict a live neighbour. It refills a page that is already cached, which a design lacking in-place update would duplicate while evicting another entry. It also covers overlapping small and large pages, where the wrong priority gives the large-page address, and each permission combination, where an inverted check faults on legal accesses. Finally it sends a lookup in the same cycle as a higher-priority command, where a wrong arbiter would produce a stray response.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_LOOKUP,
        CMD_FILL,
        CMD_INVAL,
        CMD_FLUSH
    } tlb_cmd_e;
endpackage

// File: rtl/tlb_recency.sv
// Per-set recency update: rank 0 is most-recently-used; only valid ways carry
// meaningful ranks, invalid ways form the free pool.
module tlb_recency #(
    parameter int WAYS = 4,
    parameter int RW   = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]    vld,
    input  logic [WAYS*RW-1:0] rank_in,
    input  logic               touch,
    input  logic               drop,
    input  logic [RW-1:0]      sel,
    output logic [WAYS*RW-1:0] rank_out,
    output logic [RW-1:0]      victim
);
    logic [RW-1:0] r_sel;
    logic [RW-1:0] r_w;
    logic          have_free;

    always_comb begin
        r_sel     = rank_in[sel*RW +: RW];
        victim    = '0;
        have_free = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vld[w] && !have_free) begin
                victim    = RW'(w);
                have_free = 1'b1;
            end
        end
        if (!have_free) begin
            for (int w = 0; w < WAYS; w++) begin
                if (rank_in[w*RW +: RW] == RW'(WAYS-1)) victim = RW'(w);
            end
        end
        rank_out = rank_in;
        r_w      = '0;
        for (int w = 0; w < WAYS; w++) begin
            r_w = rank_in[w*RW +: RW];
            if (touch) begin
                if (RW'(w) == sel)
                    rank_out[w*RW +: RW] = '0;
                else if (vld[w] && (!vld[sel] || r_w < r_sel))
                    rank_out[w*RW +: RW] = r_w + 1'b1;
            end else if (drop) begin
                if (RW'(w) != sel && vld[w] && vld[sel] && r_w > r_sel)
                    rank_out[w*RW +: RW] = r_w - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_array.sv
module tlb_array
    import tlb_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF   = 12,
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int IW    = $clog2(SETS),
    parameter int TAG_W = VA_W - OFF - IW,
    parameter int FR_W  = VA_W - OFF,
    parameter int RW    = $clog2(WAYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  tlb_cmd_e             cmd,
    input  logic [VA_W-1:0]      va,
    input  logic [FR_W-1:0]      fill_frame,
    input  logic                 fill_wr,
    input  logic                 fill_usr,
    output logic                 hit,
    output logic [FR_W-1:0]      hit_frame,
    output logic                 hit_wr,
    output logic                 hit_usr,
    output logic [SETS*WAYS-1:0] vld_all
);
    logic [WAYS-1:0]    vld_q   [SETS];
    logic [WAYS*RW-1:0] rank_q  [SETS];
    logic [TAG_W-1:0]   tag_q   [SETS][WAYS];
    logic [FR_W-1:0]    frame_q [SETS][WAYS];
    logic               wr_q    [SETS][WAYS];
    logic               usr_q   [SETS][WAYS];

    logic [IW-1:0]      set_idx;
    logic [TAG_W-1:0]   va_tag;
    logic [RW-1:0]      hit_way, victim, sel;
    logic [WAYS*RW-1:0] rank_nx;
    logic               touch, drop;

    assign set_idx = va[OFF+IW-1:OFF];
    assign va_tag  = va[VA_W-1:OFF+IW];

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[set_idx][w] && tag_q[set_idx][w] == va_tag) begin
                hit     = 1'b1;
                hit_way = RW'(w);
            end
        end
        hit_frame = frame_q[set_idx][hit_way];
        hit_wr    = wr_q[set_idx][hit_way];
        hit_usr   = usr_q[set_idx][hit_way];
    end

    assign sel   = (cmd == CMD_FILL && !hit) ? victim : hit_way;
    assign touch = (cmd == CMD_LOOKUP && hit) || cmd == CMD_FILL;
    assign drop  = (cmd == CMD_INVAL) && hit;

    tlb_recency #(.WAYS(WAYS), .RW(RW)) u_rec (
        .vld      (vld_q[set_idx]),
        .rank_in  (rank_q[set_idx]),
        .touch    (touch),
        .drop     (drop),
        .sel      (sel),
        .rank_out (rank_nx),
        .victim   (victim)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]  <= '0;
                rank_q[s] <= '0;
            end
        end else begin
            unique case (cmd)
                CMD_FLUSH: begin
                    for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
                end
                CMD_FILL: begin
                    vld_q[set_idx][sel] <= 1'b1;
                    rank_q[set_idx]     <= rank_nx;
                end
                CMD_LOOKUP: begin
                    if (hit) rank_q[set_idx] <= rank_nx;
                end
                CMD_INVAL: begin
                    if (hit) begin
                        vld_q[set_idx][sel] <= 1'b0;
                        rank_q[set_idx]     <= rank_nx;
                    end
                end
                CMD_IDLE: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (cmd == CMD_FILL) begin
            tag_q[set_idx][sel]   <= va_tag;
            frame_q[set_idx][sel] <= fill_frame;
            wr_q[set_idx][sel]    <= fill_wr;
            usr_q[set_idx][sel]   <= fill_usr;
        end
    end

    for (genvar s = 0; s < SETS; s++) begin : g_flat
        assign vld_all[s*WAYS +: WAYS] = vld_q[s];
    end
endmodule

// File: rtl/split_tlb.sv
module split_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int SETS      = 8,
    parameter int WAYS      = 4,
    parameter int SMALL_OFF = 12,
    parameter int LARGE_OFF = 22,
    parameter int FR_W      = VA_W - SMALL_OFF,
    parameter int LFR_W     = VA_W - LARGE_OFF,
    parameter int ENT       = SETS * WAYS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [VA_W-1:0] lk_addr,
    input  logic            lk_write,
    input  logic            lk_user,
    input  logic            fill_valid,
    input  logic            fill_large,
    input  logic [VA_W-1:0] fill_addr,
    input  logic [FR_W-1:0] fill_frame,
    input  logic            fill_wr,
    input  logic            fill_usr,
    input  logic            inv_valid,
    input  logic [VA_W-1:0] inv_addr,
    input  logic            flush,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic            rsp_fault,
    output logic [VA_W-1:0] rsp_paddr
);
    tlb_cmd_e        cmd, s_cmd, l_cmd;
    logic [VA_W-1:0] op_addr;
    logic            s_hit, l_hit, s_wr, l_wr, s_usr, l_usr;
    logic [FR_W-1:0]  s_frame;
    logic [LFR_W-1:0] l_frame;
    logic [ENT-1:0]  s_vld_all, l_vld_all;
    logic            any_hit, perm_ok, hit_n, fault_n;
    logic [VA_W-1:0] paddr_n;

    // Command arbitration: flush > invalidate > fill > lookup.
    always_comb begin
        if (flush)           cmd = CMD_FLUSH;
        else if (inv_valid)  cmd = CMD_INVAL;
        else if (fill_valid) cmd = CMD_FILL;
        else if (lk_valid)   cmd = CMD_LOOKUP;
        else                 cmd = CMD_IDLE;
    end

    always_comb begin
        s_cmd   = CMD_IDLE;
        l_cmd   = CMD_IDLE;
        op_addr = lk_addr;
        unique case (cmd)
            CMD_FLUSH: begin
                s_cmd = CMD_FLUSH;
                l_cmd = CMD_FLUSH;
            end
            CMD_INVAL: begin
                s_cmd   = CMD_INVAL;
                l_cmd   = CMD_INVAL;
                op_addr = inv_addr;
            end
            CMD_FILL: begin
                s_cmd   = fill_large ? CMD_IDLE : CMD_FILL;
                l_cmd   = fill_large ? CMD_FILL : CMD_IDLE;
                op_addr = fill_addr;
            end
            CMD_LOOKUP: begin
                s_cmd = CMD_LOOKUP;
                l_cmd = s_hit ? CMD_IDLE : CMD_LOOKUP;
            end
            CMD_IDLE: ;
            default: ;
        endcase
    end

    tlb_array #(.VA_W(VA_W), .OFF(SMALL_OFF), .SETS(SETS), .WAYS(WAYS)) u_small (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (s_cmd),
        .va         (op_addr),
        .fill_frame (fill_frame),
        .fill_wr    (fill_wr),
        .fill_usr   (fill_usr),
        .hit        (s_hit),
        .hit_frame  (s_frame),
        .hit_wr     (s_wr),
        .hit_usr    (s_usr),
        .vld_all    (s_vld_all)
    );

    tlb_array #(.VA_W(VA_W), .OFF(LARGE_OFF), .SETS(SETS), .WAYS(WAYS)) u_large (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (l_cmd),
        .va         (op_addr),
        .fill_frame (fill_frame[FR_W-1:FR_W-LFR_W]),
        .fill_wr    (fill_wr),
        .fill_usr   (fill_usr),
        .hit        (l_hit),
        .hit_frame  (l_frame),
        .hit_wr     (l_wr),
        .hit_usr    (l_usr),
        .vld_all    (l_vld_all)
    );

    always_comb begin
        any_hit = s_hit || l_hit;
        if (s_hit) begin
            perm_ok = (!lk_write || s_wr) && (!lk_user || s_usr);
            paddr_n = {s_frame, lk_addr[SMALL_OFF-1:0]};
        end else begin
            perm_ok = (!lk_write || l_wr) && (!lk_user || l_usr);
            paddr_n = {l_frame, lk_addr[LARGE_OFF-1:0]};
        end
        hit_n   = any_hit && perm_ok;
        fault_n = any_hit && !perm_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= (cmd == CMD_LOOKUP);
            rsp_hit   <= (cmd == CMD_LOOKUP) && hit_n;
            rsp_fault <= (cmd == CMD_LOOKUP) && fault_n;
            rsp_paddr <= ((cmd == CMD_LOOKUP) && hit_n) ? paddr_n : '0;
        end
    end
endmodule

// File: rtl/split_tlb_chk.sv
module split_tlb_chk #(
    parameter int ENT = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           lk_valid,
    input logic           fill_valid,
    input logic           fill_large,
    input logic           inv_valid,
    input logic           flush,
    input logic           rsp_valid,
    input logic           rsp_hit,
    input logic           rsp_fault,
    input logic [ENT-1:0] s_vld,
    input logic [ENT-1:0] l_vld
);
    // R10: a flush leaves no entry in use one cycle later
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_vld == '0 && l_vld == '0));

    // R2: a response follows only an accepted lookup
    p_rsp_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid && !fill_valid && !inv_valid && !flush));

    // R2: hit or fault only accompanies a valid response
    p_flags_need_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_fault) |-> rsp_valid);

    // R6: a response is never both a hit and a fault
    p_hit_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    // R7: an accepted small fill leaves the small array non-empty
    p_small_fill_occ_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_large && !inv_valid && !flush) |=> (s_vld != '0));

    // R7: an accepted large fill leaves the large array non-empty
    p_large_fill_occ_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_large && !inv_valid && !flush) |=> (l_vld != '0));

    // R9: an invalidate never grows either array
    p_inval_no_growth_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !flush) |=>
            ($countones(s_vld) <= $past($countones(s_vld)) &&
             $countones(l_vld) <= $past($countones(l_vld))));

    // R11: a small fill never changes large-array occupancy
    p_arrays_indep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_large && !inv_valid && !flush) |=> $stable(l_vld));
endmodule

bind split_tlb split_tlb_chk #(.ENT(ENT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .fill_valid (fill_valid),
    .fill_large (fill_large),
    .inv_valid  (inv_valid),
    .flush      (flush),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_fault  (rsp_fault),
    .s_vld      (s_vld_all),
    .l_vld      (l_vld_all)
);

// File: tb/split_tlb_test.sv
`timescale 1ns/1ps
module split_tlb_test;
    localparam int C_LK = 0, C_FILL = 1, C_INV = 2, C_FLUSH = 3;

    typedef struct packed {
        logic [1:0]  cmd;
        logic        lg;
        logic        wr;
        logic        us;
        logic [31:0] va;
        logic [19:0] fr;
        logic        pw;
        logic        pu;
        logic        eh;
        logic        ef;
        logic [31:0] ep;
        logic [7:0]  req;
    } vec_t;

    function automatic vec_t vf(input logic lg, input logic [31:0] va, input logic [19:0] fr,
                                input logic pw, input logic pu);
        return '{cmd: 2'(C_FILL), lg: lg, wr: 1'b0, us: 1'b0, va: va, fr: fr, pw: pw, pu: pu,
                 eh: 1'b0, ef: 1'b0, ep: 32'h0, req: 8'd0};
    endfunction
    function automatic vec_t vl(input logic [31:0] va, input logic wr, input logic us,
                                input logic eh, input logic ef, input logic [31:0] ep,
                                input logic [7:0] req);
        return '{cmd: 2'(C_LK), lg: 1'b0, wr: wr, us: us, va: va, fr: 20'h0, pw: 1'b0, pu: 1'b0,
                 eh: eh, ef: ef, ep: ep, req: req};
    endfunction
    function automatic vec_t vi(input logic [31:0] va);
        return '{cmd: 2'(C_INV), lg: 1'b0, wr: 1'b0, us: 1'b0, va: va, fr: 20'h0, pw: 1'b0,
                 pu: 1'b0, eh: 1'b0, ef: 1'b0, ep: 32'h0, req: 8'd0};
    endfunction
    function automatic vec_t vx();
        return '{cmd: 2'(C_FLUSH), lg: 1'b0, wr: 1'b0, us: 1'b0, va: 32'h0, fr: 20'h0, pw: 1'b0,
                 pu: 1'b0, eh: 1'b0, ef: 1'b0, ep: 32'h0, req: 8'd0};
    endfunction

    localparam int NV = 54;
    localparam vec_t VECS [NV] = '{
        // R8: four fills into small set 0, touch the oldest, overfill
        vf(0, 32'h0000_8000, 20'h000A1, 1, 1),
        vf(0, 32'h0001_0000, 20'h000B2, 1, 1),
        vf(0, 32'h0001_8000, 20'h000C3, 1, 1),
        vf(0, 32'h0002_0000, 20'h000D4, 1, 1),
        vl(32'h0000_8123, 0, 0, 1, 0, 32'h000A_1123, 8),
        vf(0, 32'h0002_8000, 20'h000E5, 1, 1),
        vl(32'h0001_0000, 0, 0, 0, 0, 32'h0, 8),
        vl(32'h0001_8004, 0, 0, 1, 0, 32'h000C_3004, 8),
        vl(32'h0002_0000, 0, 0, 1, 0, 32'h000D_4000, 8),
        vl(32'h0002_8FFF, 0, 0, 1, 0, 32'h000E_5FFF, 7),
        // R7: refill of a cached page updates in place
        vf(0, 32'h0001_8000, 20'h0C0C0, 1, 1),
        vl(32'h0001_8010, 0, 0, 1, 0, 32'h0C0C_0010, 7),
        vl(32'h0000_8000, 0, 0, 1, 0, 32'h000A_1000, 7),
        vl(32'h0002_0000, 0, 0, 1, 0, 32'h000D_4000, 7),
        vl(32'h0002_8000, 0, 0, 1, 0, 32'h000E_5000, 7),
        // R9: invalidate one way of full set 1, refill uses the freed way
        vf(0, 32'h0000_9000, 20'h10001, 1, 1),
        vf(0, 32'h0001_1000, 20'h10002, 1, 1),
        vf(0, 32'h0001_9000, 20'h10003, 1, 1),
        vf(0, 32'h0002_1000, 20'h10004, 1, 1),
        vi(32'h0001_9555),
        vf(0, 32'h0002_9000, 20'h10006, 1, 1),
        vl(32'h0000_9000, 0, 0, 1, 0, 32'h1000_1000, 9),
        vl(32'h0001_1000, 0, 0, 1, 0, 32'h1000_2000, 9),
        vl(32'h0002_1000, 0, 0, 1, 0, 32'h1000_4000, 9),
        vl(32'h0002_9000, 0, 0, 1, 0, 32'h1000_6000, 9),
        vl(32'h0001_9000, 0, 0, 0, 0, 32'h0, 9),
        // R3: small page address composition
        vf(0, 32'h0000_3000, 20'h12345, 1, 1),
        vl(32'h0000_3ABC, 0, 0, 1, 0, 32'h1234_5ABC, 3),
        // R4: large page address composition, low frame bits ignored
        vf(1, 32'h0040_0000, 20'hABC00, 1, 1),
        vl(32'h0045_6789, 0, 0, 1, 0, 32'hABC5_6789, 4),
        // R5: small page overlapping a large page wins
        vf(0, 32'h0040_4000, 20'h55555, 1, 1),
        vl(32'h0040_4234, 0, 0, 1, 0, 32'h5555_5234, 5),
        vl(32'h0040_2234, 0, 0, 1, 0, 32'hABC0_2234, 5),
        // R9: invalidate inside the large page drops only it
        vi(32'h0050_0000),
        vl(32'h0040_2234, 0, 0, 0, 0, 32'h0, 9),
        vl(32'h0040_4234, 0, 0, 1, 0, 32'h5555_5234, 9),
        // R6: permission checks
        vf(0, 32'h0000_7000, 20'h0AAAA, 0, 1),
        vl(32'h0000_7000, 1, 0, 0, 1, 32'h0, 6),
        vl(32'h0000_7010, 0, 1, 1, 0, 32'h0AAA_A010, 6),
        vf(0, 32'h0000_6000, 20'h0BBBB, 1, 0),
        vl(32'h0000_6000, 0, 1, 0, 1, 32'h0, 6),
        vl(32'h0000_6008, 1, 0, 1, 0, 32'h0BBB_B008, 6),
        // R11: large-set churn leaves the small array alone
        vf(1, 32'h0080_0000, 20'h00400, 1, 1),
        vf(1, 32'h0280_0000, 20'h00800, 1, 1),
        vf(1, 32'h0480_0000, 20'h00C00, 1, 1),
        vf(1, 32'h0680_0000, 20'h01000, 1, 1),
        vf(1, 32'h0880_0000, 20'h01400, 1, 1),
        vl(32'h0080_0000, 0, 0, 0, 0, 32'h0, 11),
        vl(32'h0881_2345, 0, 0, 1, 0, 32'h0141_2345, 11),
        vl(32'h0280_0000, 0, 0, 1, 0, 32'h0080_0000, 11),
        vl(32'h0000_3ABC, 0, 0, 1, 0, 32'h1234_5ABC, 11),
        // R10: flush empties both arrays
        vx(),
        vl(32'h0000_3ABC, 0, 0, 0, 0, 32'h0, 10),
        vl(32'h0045_6789, 0, 0, 0, 0, 32'h0, 10)
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_write, lk_user;
    logic [31:0] lk_addr;
    logic        fill_valid, fill_large, fill_wr, fill_usr;
    logic [31:0] fill_addr;
    logic [19:0] fill_frame;
    logic        inv_valid, flush;
    logic [31:0] inv_addr;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    split_tlb uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_write(lk_write), .lk_user(lk_user),
        .fill_valid(fill_valid), .fill_large(fill_large), .fill_addr(fill_addr),
        .fill_frame(fill_frame), .fill_wr(fill_wr), .fill_usr(fill_usr),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    task automatic idle_inputs();
        lk_valid = 0; lk_addr = '0; lk_write = 0; lk_user = 0;
        fill_valid = 0; fill_large = 0; fill_addr = '0; fill_frame = '0; fill_wr = 0; fill_usr = 0;
        inv_valid = 0; inv_addr = '0; flush = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_rsp(input string tag, input logic ev, input logic eh,
                             input logic ef, input logic [31:0] ep);
        checks++;
        if (rsp_valid !== ev || rsp_hit !== eh || rsp_fault !== ef || rsp_paddr !== ep) begin
            errors++;
            $display("FAIL %s: got v=%0b h=%0b f=%0b pa=%h, expected v=%0b h=%0b f=%0b pa=%h",
                     tag, rsp_valid, rsp_hit, rsp_fault, rsp_paddr, ev, eh, ef, ep);
        end
    endtask

    task automatic do_lookup(input logic [31:0] a, input logic wr, input logic us);
        lk_valid = 1; lk_addr = a; lk_write = wr; lk_user = us;
        step();
        idle_inputs();
    endtask

    task automatic do_fill(input logic lg, input logic [31:0] a, input logic [19:0] fr,
                           input logic pw, input logic pu);
        fill_valid = 1; fill_large = lg; fill_addr = a; fill_frame = fr;
        fill_wr = pw; fill_usr = pu;
        step();
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no completion, expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;

        // R1: no response while idle after reset
        check_rsp("R1 idle after reset", 0, 0, 0, 32'h0);
        // R1: first lookup misses
        do_lookup(32'h0000_3000, 0, 0);
        check_rsp("R1 lookup after reset", 1, 0, 0, 32'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            unique case (int'(v.cmd))
                C_FILL: do_fill(v.lg, v.va, v.fr, v.pw, v.pu);
                C_INV: begin
                    inv_valid = 1; inv_addr = v.va;
                    step();
                    idle_inputs();
                end
                C_FLUSH: begin
                    flush = 1;
                    step();
                    idle_inputs();
                end
                default: begin
                    do_lookup(v.va, v.wr, v.us);
                    check_rsp($sformatf("R%0d vector %0d", v.req, i), 1, v.eh, v.ef, v.ep);
                end
            endcase
        end

        // R2: lookup alongside a fill is dropped, the fill still lands
        lk_valid = 1; lk_addr = 32'h0000_1000;
        fill_valid = 1; fill_addr = 32'h0000_1000; fill_frame = 20'h77777; fill_wr = 1; fill_usr = 1;
        step();
        idle_inputs();
        check_rsp("R2 lookup lost to fill", 0, 0, 0, 32'h0);
        do_lookup(32'h0000_1FFC, 0, 0);
        check_rsp("R2 lookup after fill", 1, 1, 0, 32'h7777_7FFC);

        // R2: lookup alongside an invalidate is dropped, the invalidate lands
        lk_valid = 1; lk_addr = 32'h0000_1000;
        inv_valid = 1; inv_addr = 32'h0000_1000;
        step();
        idle_inputs();
        check_rsp("R2 lookup lost to invalidate", 0, 0, 0, 32'h0);
        do_lookup(32'h0000_1000, 0, 0);
        check_rsp("R9 page gone after invalidate", 1, 0, 0, 32'h0);

        // R2: a fill and a flush in one cycle; flush wins, nothing remains
        fill_valid = 1; fill_addr = 32'h0000_2000; fill_frame = 20'h22222; fill_wr = 1; fill_usr = 1;
        flush = 1;
        step();
        idle_inputs();
        do_lookup(32'h0000_2000, 0, 0);
        check_rsp("R2 fill lost to flush", 1, 0, 0, 32'h0);

        // R1: reset mid-run frees everything
        do_fill(0, 32'h0000_5000, 20'h33333, 1, 1);
        rst_n = 0;
        step();
        rst_n = 1;
        check_rsp("R1 response cleared by reset", 0, 0, 0, 32'h0);
        do_lookup(32'h0000_5000, 0, 0);
        check_rsp("R1 miss after second reset", 1, 0, 0, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule